// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Sequencer

This block sits between a simple host request port and a 1M x 4 fast page mode DRAM. Each host request carries a 20-bit linear word address, a read/write flag and, for writes, a 4-bit data word. The sequencer splits the address into a row half and a column half. It drives them in turn onto a shared 10-bit address bus and generates the row and column strobes, the write enable and the output enable. All intervals are counted in clock cycles and set by parameters.

After an access the row stays open. A later request to the same row is served by a column-strobe-only cycle. A request to a different row first precharges the array and then opens the new row. An open row is closed on its own before the maximum row-strobe low time runs out. A refresh request is honoured between accesses: the sequencer finishes the access in flight, closes the row, precharges and hands the bus over until the request is withdrawn.

Top module: `fpm_seq`

## Requirements
- R1: After reset the row strobe, column strobe, write enable and output enable are all high (inactive), the data driver enable and `ref_gnt` and `rsp_valid` are low, and `req_ready` is high.
- R2: The row is `req_addr[19:10]` and the column is `req_addr[9:0]`. The row is on `dram_a` when `dram_ras_n` falls, and the column is on `dram_a` when `dram_cas_n` falls.
- R3: A write is early: `dram_we_n` is already low, `dram_oe_n` is high and `dram_dq_oe` is high with the request data on `dram_dq_out` when `dram_cas_n` falls. The stored word reads back unchanged.
- R4: `dram_oe_n` is low only during reads. A read returns a one-cycle `rsp_valid` pulse in the cycle after `dram_cas_n` rises. `rsp_rdata` then holds `dram_dq_in` as sampled in the last cycle the column strobe was low.
- R5: A request whose row equals the open row causes no row strobe activity. Every column strobe pulse is exactly T_CAS cycles low, and the column strobe is low only while the row strobe is low.
- R6: A request to a row other than the open one raises the row strobe. The strobe stays high for at least T_RP cycles before it falls again with the new row.
- R7: The column strobe falls exactly T_RCD cycles after the row strobe falls, for the first access of an opened row.
- R8: The row strobe is never low for T_RAS_MAX cycles or more. A long run of accesses to one row is split into several row openings.
- R9: While `ref_req` is high no new request is accepted. The access in flight completes, then the row is closed and precharged, and `ref_gnt` is raised with both strobes high. Once `ref_req` is withdrawn, `ref_gnt` falls and the next access opens its row afresh.
- R10: `dram_dq_oe` is high only while `dram_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Linear word address, row in upper half |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh agent wants the DRAM bus |
| ref_gnt | output | 1 | Bus yielded to refresh agent |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_dq_oe | output | 1 | Data pin driver enable |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The hardest case to reach is the forced close of a row whose open time nears its limit while the host keeps hitting that same row. The bench shrinks the limit to 64 cycles and streams 40 same-row writes and then 40 same-row reads. It measures every row-strobe low interval and counts the row openings. A second hard case is a refresh request that arrives while a read is already under way. The bench forks the read and raises the refresh request two cycles later. It then checks that the read data still arrives and that the grant comes only after precharge.

// File: rtl/fpm_seq.sv
module fpm_seq #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 4,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 6,
  parameter int T_RAS_MAX = 10000,
  localparam int A_W      = (ROW_W >= COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [A_W-1:0]         dram_a,
  output logic                   dram_dq_oe,
  output logic [DQ_W-1:0]        dram_dq_out,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int CNT_W = $clog2(T_RCD + T_CAS + T_CP + T_RP + 1);
  localparam int AGE_W = $clog2(T_RAS_MAX + 1);
  localparam int LIM   = T_RAS_MAX - (T_CAS + T_CP + 3);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RCD, S_CLO, S_CPR, S_OPEN, S_PRE, S_GNT} st_t;
  st_t st;
  logic [CNT_W-1:0] cnt, hi;
  logic [AGE_W-1:0] age;
  logic [ROW_W-1:0] o_row, p_row;
  logic [COL_W-1:0] p_col;
  logic             p_we, pend;
  logic [DQ_W-1:0]  p_wd;

  wire [ROW_W-1:0] in_row  = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] in_col  = req_addr[COL_W-1:0];
  wire             age_hit = age >= AGE_W'(LIM);

  assign req_ready = (st == S_IDLE || (st == S_OPEN && !age_hit)) && !ref_req;
  assign ref_gnt   = (st == S_GNT);
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; o_row <= '0; p_row <= '0; p_col <= '0;
      p_we <= 1'b0; p_wd <= '0; pend <= 1'b0;
      dram_ras_n <= 1'b1; dram_cas_n <= 1'b1; dram_we_n <= 1'b1; dram_oe_n <= 1'b1;
      dram_a <= '0; dram_dq_oe <= 1'b0; dram_dq_out <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        p_row <= in_row; p_col <= in_col; p_we <= req_we; p_wd <= req_wdata;
      end
      unique case (st)
        S_IDLE:
          if (ref_req) st <= S_GNT;
          else if (accept) begin
            dram_a <= A_W'(in_row);
            st     <= S_ROW;
          end
        S_ROW: begin
          dram_ras_n <= 1'b0;
          o_row      <= p_row;
          pend       <= 1'b0;
          cnt        <= CNT_W'(T_RCD - 1);
          st         <= S_RCD;
        end
        S_RCD: begin
          dram_a      <= A_W'(p_col);
          dram_we_n   <= !p_we;
          dram_oe_n   <= p_we;
          dram_dq_oe  <= p_we;
          dram_dq_out <= p_wd;
          if (cnt == '0) begin
            dram_cas_n <= 1'b0;
            cnt        <= CNT_W'(T_CAS - 1);
            st         <= S_CLO;
          end else cnt <= cnt - 1'b1;
        end
        S_CLO:
          if (cnt == '0) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            rsp_valid  <= !p_we;
            rsp_rdata  <= dram_dq_in;
            cnt        <= CNT_W'(T_CP - 1);
            st         <= S_CPR;
          end else cnt <= cnt - 1'b1;
        S_CPR:
          if (cnt == '0) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        S_OPEN:
          if (ref_req || age_hit) begin
            dram_ras_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= S_PRE;
          end else if (accept) begin
            if (in_row == o_row) begin
              dram_a      <= A_W'(in_col);
              dram_we_n   <= !req_we;
              dram_oe_n   <= req_we;
              dram_dq_oe  <= req_we;
              dram_dq_out <= req_wdata;
              cnt         <= '0;
              st          <= S_RCD;
            end else begin
              dram_ras_n <= 1'b1;
              pend       <= 1'b1;
              cnt        <= CNT_W'(T_RP - 1);
              st         <= S_PRE;
            end
          end
        S_PRE:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (pend) begin
            dram_a <= A_W'(p_row);
            st     <= S_ROW;
          end else if (ref_req) st <= S_GNT;
          else st <= S_IDLE;
        S_GNT:
          if (!ref_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
      hi  <= CNT_W'(T_RP);
    end else begin
      age <= dram_ras_n ? '0 : age + 1'b1;
      hi  <= !dram_ras_n ? '0 : (hi >= CNT_W'(T_RP) ? hi : hi + 1'b1);
    end
  end

  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) !dram_cas_n |-> !dram_ras_n); // R5
  AST_RAS_LIMIT:  assert property (@(posedge clk) disable iff (!rst_n) age < AGE_W'(T_RAS_MAX)); // R8
  AST_OE_READ:    assert property (@(posedge clk) disable iff (!rst_n) !dram_oe_n |-> dram_we_n); // R4
  AST_DQ_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) dram_dq_oe |-> !dram_we_n); // R10
  AST_GNT_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) ref_gnt |-> dram_ras_n && dram_cas_n); // R9
  AST_RP_MIN:     assert property (@(posedge clk) disable iff (!rst_n) $fell(dram_ras_n) |-> $past(hi) >= CNT_W'(T_RP - 1)); // R6
endmodule

// File: tb/fpm_seq_tb_top.sv
module fpm_seq_tb_top;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS_MAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [3:0] rsp_rdata, dq_out, dq_in;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [9:0] dram_a;

  always #2 clk = ~clk;

  fpm_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_a(dram_a), .dram_dq_oe(dq_oe),
    .dram_dq_out(dq_out), .dram_dq_in(dq_in));

  // DRAM model with protocol checks
  logic [3:0] mem [0:4095];
  logic [9:0] m_row = '0, m_col = '0;
  logic [9:0] cur_row = '0, cur_col = '0;
  logic pr = 1'b1, pc = 1'b1, first_cas = 1'b0;
  int ras_falls = 0, hi_len = 100, lo_len = 0, rc = 0, cl_len = 0;
  int m_chk = 0, m_bad = 0;

  assign dq_in = cas_n ? 4'h0 : mem[{m_row[5:0], m_col[5:0]}];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] = 4'h0;
      pr = 1'b1; pc = 1'b1; hi_len = 100;
    end else begin
      if (pr && !ras_n) begin
        m_row = dram_a; ras_falls++; rc = 1; first_cas = 1'b1; lo_len = 1; m_chk++;
        if (hi_len < T_RP) begin m_bad++; $display("FAIL R6 precharge act=%0d exp>=%0d", hi_len, T_RP); end
      end else if (!ras_n) begin
        lo_len++;
        if (cas_n && pc) rc++;
      end
      if (!pr && ras_n) begin
        m_chk++; hi_len = 1;
        if (lo_len >= T_RAS_MAX) begin m_bad++; $display("FAIL R8 ras low act=%0d exp<%0d", lo_len, T_RAS_MAX); end
      end else if (ras_n) hi_len++;
      if (pc && !cas_n) begin
        m_col = dram_a; cl_len = 1; m_chk++;
        if (ras_n) begin m_bad++; $display("FAIL R5 cas without ras act=1 exp=0"); end
        if (m_row != cur_row || dram_a != cur_col) begin
          m_bad++; $display("FAIL R2 addr act=%h/%h exp=%h/%h", m_row, dram_a, cur_row, cur_col);
        end
        if (first_cas && rc != T_RCD) begin m_bad++; $display("FAIL R7 rcd act=%0d exp=%0d", rc, T_RCD); end
        first_cas = 1'b0;
        if (!we_n) begin
          if (!oe_n || !dq_oe) begin m_bad++; $display("FAIL R3 oe_n=%b dq_oe=%b exp 1/1", oe_n, dq_oe); end
          mem[{m_row[5:0], dram_a[5:0]}] = dq_out;
        end else if (oe_n || dq_oe) begin
          m_bad++; $display("FAIL R4 oe_n=%b dq_oe=%b exp 0/0", oe_n, dq_oe);
        end
      end else if (!cas_n) cl_len++;
      if (!pc && cas_n) begin
        m_chk++;
        if (cl_len != T_CAS) begin m_bad++; $display("FAIL R5 cas width act=%0d exp=%0d", cl_len, T_CAS); end
      end
      pr = ras_n; pc = cas_n;
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  function automatic logic [3:0] fdat(input int r, input int c, input int s);
    return 4'(r * 5 + c * 3 + s);
  endfunction

  task automatic issue(input logic we, input logic [9:0] r, input logic [9:0] c, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {r, c}; req_wdata = d; cur_row = r; cur_col = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (cas_n) @(negedge clk);
    while (!cas_n) @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] r, input logic [9:0] c, input logic [3:0] e);
    issue(1'b0, r, c, 4'h0);
    chk(rsp_valid === 1'b1 && rsp_rdata === e, "R4 read data", int'(rsp_rdata), int'(e));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R4 pulse width", int'(rsp_valid), 0);
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_bad++; $display("FAIL watchdog act=%0d exp<150000", cyc);
        finish_up();
      end
    end
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !ref_gnt && !rsp_valid, "R1 outputs low", {dq_oe, ref_gnt, rsp_valid}, 0);
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);

    // R3 R5 write sweep row-major: one opening per row
    f0 = ras_falls;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 8; c++) issue(1'b1, 10'(r * 9 + 1), 10'(c * 5), fdat(r, c, 1));
    chk(ras_falls - f0 == 6, "R5 page hits on write sweep", ras_falls - f0, 6);

    // R4 R5 read back row-major
    f0 = ras_falls;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 8; c++) rd(10'(r * 9 + 1), 10'(c * 5), fdat(r, c, 1));
    chk(ras_falls - f0 == 6, "R5 page hits on read sweep", ras_falls - f0, 6);

    // R6 column-major: every access changes row
    f0 = ras_falls;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 6; r++) rd(10'(r * 9 + 1), 10'(c * 5), fdat(r, c, 1));
    chk(ras_falls - f0 == 48, "R6 row miss reopen", ras_falls - f0, 48);

    // R8 long same-row stream, with upper row bits set
    f0 = ras_falls;
    for (int c = 0; c < 40; c++) issue(1'b1, 10'h3C7, 10'(c), fdat(7, c, 2));
    chk(ras_falls - f0 >= 3, "R8 forced close on writes", ras_falls - f0, 3);
    f0 = ras_falls;
    for (int c = 0; c < 40; c++) rd(10'h3C7, 10'(c), fdat(7, c, 2));
    chk(ras_falls - f0 >= 3, "R8 forced close on reads", ras_falls - f0, 3);

    // R3 overwrite then read
    issue(1'b1, 10'h001, 10'h000, 4'hA);
    rd(10'h001, 10'h000, 4'hA);

    // R9 refresh arriving during a read
    fork
      rd(10'h001, 10'h005, fdat(0, 1, 1));
      begin repeat (2) @(negedge clk); ref_req = 1'b1; end
    join
    chk(req_ready === 1'b0, "R9 no accept under refresh", int'(req_ready), 0);
    while (!ref_gnt) @(negedge clk);
    chk(ras_n && cas_n, "R9 strobes high at grant", {ras_n, cas_n}, 3);
    chk(hi_len >= T_RP, "R9 precharge before grant", hi_len, T_RP);
    repeat (5) @(negedge clk);
    chk(ref_gnt === 1'b1 && ras_n === 1'b1, "R9 grant held", {ref_gnt, ras_n}, 3);
    ref_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ref_gnt === 1'b0, "R9 grant released", int'(ref_gnt), 0);
    f0 = ras_falls;
    rd(10'h001, 10'h005, fdat(0, 1, 1));
    chk(ras_falls - f0 == 1, "R9 row reopened after refresh", ras_falls - f0, 1);

    // R9 refresh with row open and idle
    @(negedge clk); ref_req = 1'b1;
    while (!ref_gnt) @(negedge clk);
    chk(ras_n && cas_n && !req_ready, "R9 idle refresh grant", {ras_n, cas_n, req_ready}, 6);
    ref_req = 1'b0;
    rd(10'h3C7, 10'h027, fdat(7, 39, 2));

    repeat (4) @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule